// File: doc/BRIEF.md
# Multi-domain clock divider update controller

This block derives clock-enable strobes for one processor/high-speed bus domain and a parameterised number of peripheral bus domains from a single main clock. Each domain has its own divider selection. Downstream logic keeps running while software changes that selection through a small register port. A change is first held in a staging copy. It then takes effect in every domain on the same clock edge, the next time all divider counters sit at zero, so all strobes restart in phase.

A ready flag goes low as soon as a change is accepted and comes back one cycle after the commit. If the interrupt enable is set, a sticky interrupt status is raised when the ready flag returns. It stays set until software writes a one to the clear register. A selection write is dropped if a change is still pending, or if the new setting would make any peripheral domain faster than the processor domain. In both cases every setting stays as it was. Only the domain that was written changes, so processor speed can be scaled while peripheral rates stay fixed.

Top module: `clkdiv_commit_ctrl`

## Requirements
- R1: Out of reset every selection reads 0 (divide by 1), the processor tick and all peripheral ticks are high on every cycle, the ready flag is 1 and the interrupt is 0.
- R2: A selection holds an enable in bit 3 and an exponent in bits 2:0. When the enable is set the domain's tick is high one cycle in every 2^(exponent+1) cycles. When the enable is clear the ratio is 1 and the exponent has no effect.
- R3: A selection write accepted while ready is 1 drives ready to 0 on the next cycle. The read-back value of that domain stays at the old setting until the commit, and the other domains are left unchanged.
- R4: A staged change is committed on the first cycle in which every tick is high. All domains switch on that same edge, and the new periods start counting from it.
- R5: The ready flag returns to 1 exactly two cycles after the cycle in which the commit took place.
- R6: A selection write that arrives while ready is 0 is ignored. Once the pending change completes, that domain reads back the value from before the ignored write.
- R7: A selection write whose processor ratio would exceed any peripheral ratio is rejected. Ready stays 1 and every selection and tick period is unchanged.
- R8: With bit 0 of the interrupt-enable register set, the interrupt output rises on the same cycle the ready flag returns and then stays high (sticky). With it clear, the interrupt stays 0.
- R9: Writing 1 to bit 0 of the clear register drops the interrupt on the next cycle. If that write coincides with a new set event, the set wins.
- R10: Every peripheral tick coincides with a processor tick.
- R11: Address map: 0 is the processor selection; 1 to NUM_PB are the peripheral selections; NUM_PB+1 is status (bit 0 ready, bit 1 interrupt); NUM_PB+2 is interrupt enable; NUM_PB+3 is the clear register. Reads are combinational and zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| cpu_tick | output | 1 | Processor/high-speed bus domain enable strobe |
| pb_tick | output | NUM_PB | Peripheral bus domain enable strobes |
| clk_ready | output | 1 | Divider setting settled (no change pending) |
| irq | output | 1 | Sticky change-done interrupt |

## Verification
A write is captured on the rising edge that ends its cycle. Ready must therefore already read 0 at the next falling edge, and the bench checks it there. The commit lands on the first cycle, counted from the cycle after that edge, in which all ticks are high. Ready and the interrupt come back two falling edges after that cycle, and the bench measures this as an exact latency rather than a bound. Read data is combinational, so it is sampled a moment after the read address is set. Tick periods are measured between consecutive strobes observed at falling edges, so no check depends on process order at the active edge.

// File: rtl/cdu_pkg.sv
package cdu_pkg;

   // Widest exponent field any instance may use; bounds the counter width.
   localparam int unsigned CDU_EXP_MAX = 4;
   localparam int unsigned CDU_LG_W    = CDU_EXP_MAX + 1;

   typedef enum logic [1:0] {
      CDU_IDLE = 2'd0,
      CDU_PEND = 2'd1,
      CDU_DONE = 2'd2
   } cdu_state_e;

   // log2 of the divide ratio encoded by an enable bit and an exponent.
   function automatic logic [CDU_LG_W-1:0] cdu_lg(input logic en,
                                                  input logic [CDU_EXP_MAX-1:0] e);
      return en ? ({1'b0, e} + CDU_LG_W'(1)) : '0;
   endfunction

endpackage

// File: rtl/cdu_div_counter.sv
module cdu_div_counter
   import cdu_pkg::*;
#(
   parameter int unsigned EXP_W = 3
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic [EXP_W:0] sel_act,
   input  logic [EXP_W:0] sel_new,
   input  logic           commit,
   output logic           tick
);
   localparam int unsigned CNT_W = 1 << EXP_W;

   logic [EXP_W:0]        sel_eff;
   logic [CDU_LG_W-1:0]   lg;
   logic [CNT_W:0]        span;
   logic [CNT_W-1:0]      term;
   logic [CNT_W-1:0]      cnt_q;

   // On the commit cycle every counter sits at zero, so stepping with the
   // new terminal count starts the new period from this edge.
   assign sel_eff = commit ? sel_new : sel_act;
   assign lg      = cdu_lg(sel_eff[EXP_W], CDU_EXP_MAX'(sel_eff[EXP_W-1:0]));
   assign span    = (CNT_W+1)'(1) << lg;
   assign term    = CNT_W'(span - (CNT_W+1)'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (cnt_q == term)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + 1'b1;
   end

   assign tick = (cnt_q == '0);

endmodule

// File: rtl/cdu_order_check.sv
module cdu_order_check
   import cdu_pkg::*;
#(
   parameter int unsigned NUM_PB = 3,
   parameter int unsigned EXP_W  = 3
)(
   input  logic [NUM_PB:0][EXP_W:0] cand,
   output logic                     ok
);
   logic [CDU_LG_W-1:0] lg_cpu;
   logic [NUM_PB-1:0]   pb_ok;

   assign lg_cpu = cdu_lg(cand[0][EXP_W], CDU_EXP_MAX'(cand[0][EXP_W-1:0]));

   // Processor ratio must not exceed any peripheral ratio.
   for (genvar i = 0; i < NUM_PB; i++) begin : g_pb
      logic [CDU_LG_W-1:0] lg_pb;
      assign lg_pb    = cdu_lg(cand[i+1][EXP_W], CDU_EXP_MAX'(cand[i+1][EXP_W-1:0]));
      assign pb_ok[i] = (lg_cpu <= lg_pb);
   end

   assign ok = &pb_ok;

endmodule

// File: rtl/cdu_commit_seq.sv
module cdu_commit_seq
   import cdu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic accept,
   input  logic all_zero,
   input  logic ien,
   input  logic clr,
   output logic commit,
   output logic ready,
   output logic irq_stat
);
   cdu_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         CDU_IDLE: if (accept)   st_d = CDU_PEND;
         CDU_PEND: if (all_zero) st_d = CDU_DONE;
         CDU_DONE:               st_d = CDU_IDLE;
         default:                st_d = CDU_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         st_q <= CDU_IDLE;
      else
         st_q <= st_d;
   end

   assign commit = (st_q == CDU_PEND) && all_zero;
   assign ready  = (st_q == CDU_IDLE);

   // Set has priority over a simultaneous clear.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         irq_stat <= 1'b0;
      else if ((st_q == CDU_DONE) && ien)
         irq_stat <= 1'b1;
      else if (clr)
         irq_stat <= 1'b0;
   end

endmodule

// File: rtl/clkdiv_commit_ctrl.sv
module clkdiv_commit_ctrl
   import cdu_pkg::*;
#(
   parameter int unsigned NUM_PB = 3,
   parameter int unsigned EXP_W  = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              cpu_tick,
   output logic [NUM_PB-1:0] pb_tick,
   output logic              clk_ready,
   output logic              irq
);
   localparam int unsigned SEL_W = EXP_W + 1;
   localparam int unsigned NDOM  = NUM_PB + 1;
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PB + 1);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(NUM_PB + 2);
   localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(NUM_PB + 3);

   // Elaboration-time parameter checks
   if (NUM_PB < 1) begin : g_bad_pb
      $error("NUM_PB must be at least 1");
   end
   if ((EXP_W < 1) || (EXP_W > CDU_EXP_MAX)) begin : g_bad_exp
      $error("EXP_W out of supported range");
   end
   if (DATA_W < SEL_W || DATA_W < 2) begin : g_bad_data
      $error("DATA_W too narrow for a selection field");
   end
   if ((1 << ADDR_W) < (NUM_PB + 4)) begin : g_bad_addr
      $error("ADDR_W too narrow for the register map");
   end

   logic [NDOM-1:0][SEL_W-1:0] sel_act_q;
   logic [NDOM-1:0][SEL_W-1:0] sel_stg_q;
   logic [NDOM-1:0][SEL_W-1:0] cand;
   logic [NDOM-1:0]            tick_v;
   logic                       ien_q;
   logic                       sel_wr;
   logic                       order_ok;
   logic                       accept;
   logic                       commit;
   logic                       all_zero;
   logic                       clr;
   logic                       wr_unused;

   assign wr_unused = ^wr_data;

   // Candidate: active settings with the addressed domain replaced.
   always_comb begin
      cand = sel_act_q;
      for (int d = 0; d < NDOM; d++) begin
         if (wr_addr == ADDR_W'(d))
            cand[d] = wr_data[SEL_W-1:0];
      end
   end

   cdu_order_check #(
      .NUM_PB (NUM_PB),
      .EXP_W  (EXP_W)
   ) u_order (
      .cand (cand),
      .ok   (order_ok)
   );

   assign sel_wr = wr_en && (wr_addr < ADDR_W'(NDOM));
   assign accept = sel_wr && clk_ready && order_ok;
   assign clr    = wr_en && (wr_addr == A_ICLR) && wr_data[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_act_q <= '0;
         sel_stg_q <= '0;
         ien_q     <= 1'b0;
      end else begin
         if (accept)
            sel_stg_q <= cand;
         if (commit)
            sel_act_q <= sel_stg_q;
         if (wr_en && (wr_addr == A_IEN))
            ien_q <= wr_data[0];
      end
   end

   for (genvar d = 0; d < NDOM; d++) begin : g_dom
      cdu_div_counter #(
         .EXP_W (EXP_W)
      ) u_cnt (
         .clk     (clk),
         .rst_n   (rst_n),
         .sel_act (sel_act_q[d]),
         .sel_new (sel_stg_q[d]),
         .commit  (commit),
         .tick    (tick_v[d])
      );
   end

   assign all_zero = &tick_v;
   assign cpu_tick = tick_v[0];
   assign pb_tick  = tick_v[NDOM-1:1];

   cdu_commit_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .all_zero (all_zero),
      .ien      (ien_q),
      .clr      (clr),
      .commit   (commit),
      .ready    (clk_ready),
      .irq_stat (irq)
   );

   always_comb begin
      rd_data = '0;
      for (int d = 0; d < NDOM; d++) begin
         if (rd_addr == ADDR_W'(d))
            rd_data[SEL_W-1:0] = sel_act_q[d];
      end
      if (rd_addr == A_STAT)
         rd_data[1:0] = {irq, clk_ready};
      if (rd_addr == A_IEN)
         rd_data[0] = ien_q;
   end

endmodule

// File: rtl/cdu_clkdiv_ctrl_chk.sv
module cdu_clkdiv_ctrl_chk #(
   parameter int unsigned NUM_PB = 3,
   parameter int unsigned ADDR_W = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              clr_bit,
   input logic              cpu_tick,
   input logic [NUM_PB-1:0] pb_tick,
   input logic              clk_ready,
   input logic              irq,
   input logic              commit,
   input logic              accept
);
   localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'(NUM_PB + 3);

   AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !clk_ready); // R3

   AST_COMMIT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      commit |-> (cpu_tick && (&pb_tick))); // R4

   AST_READY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clk_ready) |-> $past(commit, 2)); // R5

   AST_IRQ_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> $rose(clk_ready)); // R8

   AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && (wr_addr == A_ICLR) && clr_bit)) |=> irq); // R9

   for (genvar i = 0; i < NUM_PB; i++) begin : g_nest
      AST_PB_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
         pb_tick[i] |-> cpu_tick); // R10
   end

endmodule

bind clkdiv_commit_ctrl cdu_clkdiv_ctrl_chk #(
   .NUM_PB (NUM_PB),
   .ADDR_W (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .clr_bit   (wr_data[0]),
   .cpu_tick  (cpu_tick),
   .pb_tick   (pb_tick),
   .clk_ready (clk_ready),
   .irq       (irq),
   .commit    (commit),
   .accept    (accept)
);

// File: tb/clkdiv_commit_ctrl_tb_top.sv
`timescale 1ns/1ps
module clkdiv_commit_ctrl_tb_top;
   localparam int NPB = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [2:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cpu_tick;
   logic [NPB-1:0] pb_tick;
   logic       clk_ready;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   logic [7:0] exp_sel [0:NPB];

   always #10 clk = ~clk;

   clkdiv_commit_ctrl #(.NUM_PB(NPB), .EXP_W(3), .DATA_W(8), .ADDR_W(3)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .cpu_tick(cpu_tick), .pb_tick(pb_tick),
      .clk_ready(clk_ready), .irq(irq));

   // {accept, addr, selection}: bit 3 enable, bits 2:0 exponent
   localparam logic [15:0] VEC [0:9] = '{
      16'h0008,  // cpu /2 over pb /1: rejected
      16'h110A,  // pb0 /8
      16'h1209,  // pb1 /4
      16'h1308,  // pb2 /2
      16'h1008,  // cpu /2
      16'h0009,  // cpu /4 over pb2 /2: rejected
      16'h0300,  // pb2 /1 under cpu /2: rejected
      16'h130F,  // pb2 /256
      16'h0207,  // pb1 disabled -> /1 under cpu /2: rejected
      16'h1000   // cpu /1
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   function automatic int ratio(input logic [7:0] s);
      return s[3] ? (1 << (s[2:0] + 1)) : 1;
   endfunction

   function automatic logic tick_of(input int d);
      return (d == 0) ? cpu_tick : pb_tick[d-1];
   endfunction

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      rd_addr = 3'(a);
      #1;
      d = rd_data;
   endtask

   // Called at the falling edge just after the write edge. Returns the
   // number of falling edges from the first all-ticks cycle to ready.
   task automatic wait_commit(output int lat, output logic irq_early);
      int n = 0;
      int seen = -1;
      irq_early = 1'b0;
      while (!clk_ready && n < 2000) begin
         if (seen < 0 && cpu_tick && (&pb_tick)) seen = n;
         irq_early |= irq;
         @(negedge clk);
         n++;
      end
      lat = (seen < 0) ? -1 : n - seen;
   endtask

   task automatic period(input int d, output int per);
      int n = 0;
      while (!tick_of(d) && n < 600) begin @(negedge clk); n++; end
      per = 0;
      do begin
         if ((|pb_tick) && !cpu_tick)
            check("R10 pb tick without cpu tick", 0, 1);
         @(negedge clk);
         per++;
      end while (!tick_of(d) && per < 600);
   endtask

   initial begin
      #(20ns * 150000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      int lat, per;
      logic ie;
      for (int d = 0; d <= NPB; d++) exp_sel[d] = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 ready", clk_ready, 1);
      check("R1 irq", irq, 0);
      for (int c = 0; c < 2; c++) begin
         check("R1 ticks", {cpu_tick, pb_tick}, 4'hF);
         @(negedge clk);
      end
      rd(0, v); check("R1 cpu sel", v, 0);
      rd(NPB + 1, v); check("R11 status", v, 8'h01);

      // Table walk: R2 R3 R4 R5 R7
      for (int i = 0; i < 10; i++) begin
         int a;
         logic [7:0] d;
         logic acc;
         a = int'(VEC[i][11:8]); d = VEC[i][7:0]; acc = VEC[i][12];
         wr(a, d);
         if (acc) begin
            check("R3 ready low after write", clk_ready, 0);
            rd(a, v); check("R3 old value until commit", v, exp_sel[a]);
            wait_commit(lat, ie);
            check("R5 ready two cycles after commit", lat, 2);
            exp_sel[a] = d;
         end else begin
            check("R7 rejected write keeps ready", clk_ready, 1);
         end
         for (int k = 0; k <= NPB; k++) begin
            rd(k, v); check("R3 R7 R11 readback", v, exp_sel[k]);
         end
         period(a, per);
         check("R2 R4 tick period", per, ratio(exp_sel[a]));
         check("R8 no irq while disabled", irq, 0);
      end

      // R6 write during pending change is ignored
      wr(1, 8'h09);
      wr(2, 8'h0B);
      wait_commit(lat, ie);
      exp_sel[1] = 8'h09;
      rd(1, v); check("R6 accepted write", v, 8'h09);
      rd(2, v); check("R6 ignored write", v, exp_sel[2]);
      period(2, per); check("R6 period unchanged", per, ratio(exp_sel[2]));

      // R8 interrupt with enable set
      wr(NPB + 2, 8'h01);
      rd(NPB + 2, v); check("R11 enable readback", v, 8'h01);
      wr(3, 8'h0A);
      wait_commit(lat, ie);
      check("R8 irq not early", ie, 0);
      check("R8 irq with ready", irq, 1);
      repeat (5) @(negedge clk);
      check("R8 irq sticky", irq, 1);
      rd(NPB + 1, v); check("R8 R11 status", v, 8'h03);

      // R9 clear
      wr(NPB + 3, 8'h01);
      check("R9 cleared", irq, 0);

      // R9 set wins over simultaneous clear
      wr(3, 8'h0B);
      begin
         int n = 0;
         while (!(cpu_tick && (&pb_tick)) && n < 600) begin @(negedge clk); n++; end
      end
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(NPB + 3); wr_data = 8'h01;
      @(negedge clk);
      wr_en = 1'b0;
      check("R5 ready after commit", clk_ready, 1);
      check("R9 set wins over clear", irq, 1);

      finish_run();
   end
endmodule